// File: doc/BRIEF.md
# Per-Channel Optical Black Level Averager

This block sits behind the analog-to-digital converters of a two-output linear CCD. Odd-numbered and even-numbered elements leave the sensor on separate channels, and each channel delivers 3797 samples per line. The samples arrive as words tagged with their channel and with their position in that channel's line. The position counts from 0, and position k of the odd channel is element D(2k+1) or S(2k-73). The block averages ten shielded reference elements on each channel to get that channel's black level. It then subtracts that level from every active pixel of the same channel and clamps the result at zero.

The reference window is positions 2 to 11 on both channels. On the odd channel these are D5, D7 and so on up to D23. On the even channel they are D6 up to D24. Active pixels occupy positions 37 to 3786, which are S1..S7499 on the odd channel and S2..S7500 on the even channel. The leading dummies, the rest of the shielded elements and the trailing dummies produce no output. The average is exact: the bench takes the floor of the sum divided by ten, and the design gets the same value with a reciprocal multiply and a shift. Each black level is registered as soon as its last reference sample arrives, which is long before position 37, and it holds until the next line.

Top module: `ccd_blk_level`

## Requirements
- R1: `blk_odd` becomes floor(S/10), where S is the sum of the ten odd-channel samples (`in_chan`=0) at positions 2..11 since the last line start. It appears in the cycle after the position-11 sample is accepted.
- R2: `blk_even` follows the same rule for even-channel samples (`in_chan`=1).
- R3: A black level changes only in the cycle after its own channel's position-11 sample. At all other times, and for the whole rest of the line, it keeps its value.
- R4: Samples at positions 0, 1 and 12..3796, and samples of the other channel, do not affect a channel's black level.
- R5: An accepted sample at a position in 37..3786 gives `out_valid`=1 one cycle later, with `out_chan` equal to its channel tag. A sample at any other position, or no sample, gives `out_valid`=0.
- R6: `out_data` equals the sample minus the current black level of the same channel, or 0 when the sample is not above that black level.
- R7: A `line_start` pulse discards any reference samples summed before it on both channels. A sample accepted in the same cycle as the pulse counts toward the new sum.
- R8: During reset and after it, `out_valid`, `out_data`, `out_chan`, `blk_odd` and `blk_even` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of a line; clears the running sums |
| in_valid | input | 1 | A sample is present this cycle |
| in_chan | input | 1 | Channel tag: 0 = odd elements, 1 = even elements |
| in_idx | input | 12 | Position of the sample within its channel's line (0..3796) |
| in_data | input | 12 | Digitised sample word |
| out_valid | output | 1 | Corrected active pixel present |
| out_chan | output | 1 | Channel tag of the corrected pixel |
| out_data | output | 12 | Black-corrected pixel, clamped at zero |
| blk_odd | output | 12 | Current odd-channel black level |
| blk_even | output | 12 | Current even-channel black level |

## Verification
The assertions assume that positions arrive in rising order within a line and never go beyond 3796. They also assume that `in_chan`, `in_idx` and `in_data` are meaningful only while `in_valid` is high. The bench drives every full line as interleaved odd/even samples in position order, with `line_start` on the first sample. The one exception is a directed partial sequence, which splits a reference window with a lone `line_start` pulse to exercise R7 while keeping the rising-position order. Stimulus values are chosen so that some active samples fall below the black level and some reference windows sum to values with non-zero remainders and to the full-scale maximum.

// File: rtl/ccd_blk_pkg.sv
package ccd_blk_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH_ODD = 1'b0, CH_EVEN = 1'b1} chan_e;
endpackage

// File: rtl/ccd_blk_accum.sv
// Per-channel reference-window accumulator with an exact divide by the window size.
module ccd_blk_accum
  import ccd_blk_pkg::*;
#(
  parameter int    DATA_W    = 12,
  parameter int    IDX_W     = 12,
  parameter int    BLK_FIRST = 2,
  parameter int    BLK_COUNT = 10,
  parameter chan_e CH_ID     = CH_ODD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic              in_chan,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] blk,
  output logic              load_evt
);
  localparam int CW    = $clog2(BLK_COUNT);
  localparam int SUM_W = DATA_W + CW;
  localparam int SH    = SUM_W + CW;
  localparam logic [SH:0] RECIP = (SH+1)'(((1 << SH) + BLK_COUNT - 1) / BLK_COUNT);
  localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(BLK_FIRST);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(BLK_FIRST + BLK_COUNT - 1);

  // floor(s / BLK_COUNT) by reciprocal multiply; exact for every s below 2**SUM_W
  function automatic logic [DATA_W-1:0] div_window(input logic [SUM_W-1:0] s);
    logic [SUM_W+SH:0] prod;
    prod = {{(SH+1){1'b0}}, s} * {{SUM_W{1'b0}}, RECIP};
    return prod[SH +: DATA_W];
  endfunction

  logic [SUM_W-1:0] sum_q, sum_nx;
  logic             in_win;

  assign in_win   = in_valid && (in_chan == CH_ID) &&
                    (in_idx >= FIRST_I) && (in_idx <= LAST_I);
  assign load_evt = in_win && (in_idx == LAST_I);
  assign sum_nx   = (clr ? '0 : sum_q) +
                    (in_win ? {{(SUM_W-DATA_W){1'b0}}, in_data} : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      blk   <= '0;
    end else begin
      if (load_evt) begin
        blk   <= div_window(sum_nx);
        sum_q <= '0;
      end else if (clr || in_win) begin
        sum_q <= sum_nx;
      end
    end
  end
endmodule

// File: rtl/ccd_blk_sub.sv
// Active-pixel gate and clamped black subtraction, one register stage.
module ccd_blk_sub
  import ccd_blk_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int IDX_W     = 12,
  parameter int ACT_FIRST = 37,
  parameter int ACT_COUNT = 3750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_chan,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] blk_odd,
  input  logic [DATA_W-1:0] blk_even,
  output logic              out_valid,
  output logic              out_chan,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [IDX_W-1:0] ACT_LO = IDX_W'(ACT_FIRST);
  localparam logic [IDX_W-1:0] ACT_HI = IDX_W'(ACT_FIRST + ACT_COUNT - 1);

  function automatic logic [DATA_W-1:0] sub_floor0(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  logic              act_hit;
  logic [DATA_W-1:0] blk_sel;

  assign act_hit = in_valid && (in_idx >= ACT_LO) && (in_idx <= ACT_HI);
  assign blk_sel = (chan_e'(in_chan) == CH_EVEN) ? blk_even : blk_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= act_hit;
      if (act_hit) begin
        out_chan <= in_chan;
        out_data <= sub_floor0(in_data, blk_sel);
      end
    end
  end
endmodule

// File: rtl/ccd_blk_level.sv
module ccd_blk_level
  import ccd_blk_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int IDX_W     = 12,
  parameter int BLK_FIRST = 2,
  parameter int BLK_COUNT = 10,
  parameter int ACT_FIRST = 37,
  parameter int ACT_COUNT = 3750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              in_valid,
  input  logic              in_chan,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] blk_odd,
  output logic [DATA_W-1:0] blk_even
);
  logic [DATA_W-1:0] blk_lv [NUM_CH];
  logic [NUM_CH-1:0] blk_load;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ccd_blk_accum #(
      .DATA_W(DATA_W), .IDX_W(IDX_W),
      .BLK_FIRST(BLK_FIRST), .BLK_COUNT(BLK_COUNT),
      .CH_ID(chan_e'(g))
    ) u_accum (
      .clk(clk), .rst_n(rst_n), .clr(line_start),
      .in_valid(in_valid), .in_chan(in_chan), .in_idx(in_idx), .in_data(in_data),
      .blk(blk_lv[g]), .load_evt(blk_load[g])
    );
  end

  assign blk_odd  = blk_lv[CH_ODD];
  assign blk_even = blk_lv[CH_EVEN];

  ccd_blk_sub #(
    .DATA_W(DATA_W), .IDX_W(IDX_W),
    .ACT_FIRST(ACT_FIRST), .ACT_COUNT(ACT_COUNT)
  ) u_sub (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_chan(in_chan), .in_idx(in_idx), .in_data(in_data),
    .blk_odd(blk_odd), .blk_even(blk_even),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );
endmodule

// File: rtl/ccd_blk_chk.sv
module ccd_blk_chk #(
  parameter int DATA_W    = 12,
  parameter int IDX_W     = 12,
  parameter int BLK_FIRST = 2,
  parameter int BLK_COUNT = 10,
  parameter int ACT_FIRST = 37,
  parameter int ACT_COUNT = 3750
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_chan,
  input logic [IDX_W-1:0]  in_idx,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] blk_odd,
  input logic [DATA_W-1:0] blk_even,
  input logic [1:0]        load_evt
);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(BLK_FIRST + BLK_COUNT - 1);
  localparam logic [IDX_W-1:0] ACT_LO = IDX_W'(ACT_FIRST);
  localparam logic [IDX_W-1:0] ACT_HI = IDX_W'(ACT_FIRST + ACT_COUNT - 1);

  p_load_pos_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt[0] |-> (in_valid && !in_chan && in_idx == LAST_I));
  p_load_pos_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt[1] |-> (in_valid && in_chan && in_idx == LAST_I));
  p_hold_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt[0] |=> $stable(blk_odd));
  p_hold_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt[1] |=> $stable(blk_even));
  p_no_out_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || in_idx < ACT_LO || in_idx > ACT_HI) |=> !out_valid);
  p_out_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_not_above_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= $past(in_data)));
endmodule

bind ccd_blk_level ccd_blk_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .BLK_FIRST(BLK_FIRST),
  .BLK_COUNT(BLK_COUNT), .ACT_FIRST(ACT_FIRST), .ACT_COUNT(ACT_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
  .in_idx(in_idx), .in_data(in_data), .out_valid(out_valid),
  .out_data(out_data), .blk_odd(blk_odd), .blk_even(blk_even),
  .load_evt(blk_load)
);

// File: tb/ccd_blk_level_bench.sv
module ccd_blk_level_bench;
  localparam int LINE = 3797;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_chan = 1'b0;
  logic [11:0] in_idx = '0;
  logic [11:0] in_data = '0;
  logic        out_valid, out_chan;
  logic [11:0] out_data, blk_odd, blk_even;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ccd_blk_level u_ccd_blk_level (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_valid(in_valid),
    .in_chan(in_chan), .in_idx(in_idx), .in_data(in_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
    .blk_odd(blk_odd), .blk_even(blk_even)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_sum [2];
  int  m_blk [2];
  bit  e_ov;
  int  e_oc, e_od;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sum = '{0, 0}; m_blk = '{0, 0};
      e_ov = 0; e_oc = 0; e_od = 0;
    end else begin
      int c, p, d;
      c = int'(in_chan); p = int'(in_idx); d = int'(in_data);
      e_ov = 0;
      if (in_valid && p >= 37 && p <= 3786) begin
        e_ov = 1; e_oc = c;
        e_od = (d > m_blk[c]) ? d - m_blk[c] : 0;
      end
      if (line_start) m_sum = '{0, 0};
      if (in_valid && p >= 2 && p <= 11) begin
        m_sum[c] += d;
        if (p == 11) begin
          m_blk[c] = m_sum[c] / 10;
          m_sum[c] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R5 out_valid", int'(out_valid), int'(e_ov));
      check("R1 blk_odd", int'(blk_odd), m_blk[0]);
      check("R2 blk_even", int'(blk_even), m_blk[1]);
      if (e_ov) begin
        check("R6 out_data", int'(out_data), e_od);
        check("R5 out_chan", int'(out_chan), e_oc);
      end
    end
  end

  function automatic int pix(int ln, int ch, int p, int kind);
    if (kind == 2) return (p >= 2 && p <= 11) ? 4095 : (p * 7) % 4096;
    if (p >= 2 && p <= 11) return 100 + ((p * 29 + ln * 7 + ch * 13) % 50);
    if (kind == 1 && (p < 37 || p > 3786)) return 4095;
    if (p < 37 || p > 3786) return 90 + (p % 7);
    return (p * 97 + ln * 131 + ch * 53) % 4096;
  endfunction

  task automatic send(input bit ls, input bit ch, input int p, input int d);
    @(negedge clk); #2;
    line_start = ls; in_valid = 1'b1; in_chan = ch;
    in_idx = 12'(p); in_data = 12'(d);
  endtask

  task automatic idle();
    @(negedge clk); #2;
    line_start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run_line(input int ln, input int kind);
    int held_o, held_e;
    held_o = 0; held_e = 0;
    for (int p = 0; p < LINE; p++) begin
      send(p == 0, 1'b0, p, pix(ln, 0, p, kind));
      send(1'b0, 1'b1, p, pix(ln, 1, p, kind));
      if (p == 20) begin held_o = int'(blk_odd); held_e = int'(blk_even); end
      if (p == 3000) begin
        check("R3 odd held mid-line", int'(blk_odd), held_o);
        check("R3 even held mid-line", int'(blk_even), held_e);
      end
    end
    idle();
  endtask

  function automatic int win_avg(int ln, int ch, int kind);
    int s;
    s = 0;
    for (int p = 2; p <= 11; p++) s += pix(ln, ch, p, kind);
    return s / 10;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R8 out_valid in reset", int'(out_valid), 0);
    check("R8 blk_odd in reset", int'(blk_odd), 0);
    check("R8 out_data in reset", int'(out_data), 0);
    @(negedge clk); #2; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 blk_even after reset", int'(blk_even), 0);
    check("R8 out_chan after reset", int'(out_chan), 0);

    run_line(0, 0);
    check("R1 odd window average", int'(blk_odd), win_avg(0, 0, 0));
    check("R2 even window average", int'(blk_even), win_avg(0, 1, 0));

    run_line(1, 1);
    check("R4 odd ignores non-window", int'(blk_odd), win_avg(1, 0, 1));
    check("R4 even ignores non-window", int'(blk_even), win_avg(1, 1, 1));

    run_line(2, 2);
    check("R1 odd full-scale average", int'(blk_odd), 4095);
    check("R2 even full-scale average", int'(blk_even), 4095);

    // R7: partial window, then a lone line_start, then the rest of the window
    for (int p = 0; p < 6; p++) send(p == 0, 1'b0, p, 1000);
    @(negedge clk); #2; in_valid = 1'b0; line_start = 1'b1;
    for (int p = 6; p < 12; p++) send(1'b0, 1'b0, p, 20);
    idle();
    @(negedge clk); #2;
    check("R7 line_start discards partial sum", int'(blk_odd), 12);
    check("R7 even untouched", int'(blk_even), 4095);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule